// File: doc/BRIEF.md
# CTS Change Interrupt Status Unit

This block raises an interrupt when the clear-to-send line of a serial port changes level. The asynchronous line is brought into the core clock domain by a synchroniser. Any change of the synchronised level, either rising or falling, sets a raw status bit. A mask bit gates that status onto a single interrupt output. Software reaches all of this through a small register bus.

Clearing is edge-based. A hidden clear latch behind the clear address removes the status only when the latch goes from 0 to 1. The latch drops back to 0 by itself once the status reads 0. If a new line change arrives in the same cycle as a clear, the status stays set and the latch stays at 1. Further writes of 1 then do nothing. The driver recovers by first writing 0 to the clear bit, which reopens the latch, and then writing 1.

The bus is word-addressed on byte offsets. Raw status is at 0x0, the mask at 0x4, masked status at 0x8 and the write-only clear at 0xC. The CTS source is bit 1 of each register.

Top module: `cts_evt_irq`

## Requirements
- R1: A rising or a falling change of `cts_in` sets raw status (bit 1 at offset 0x0). The change must be present at a rising clock edge. Status then reads 1 after the third clock edge counted from that one, and not before.
- R2: A write to offset 0xC with bit 1 set, while the clear latch is 0 and no change event is due, clears raw status at that clock edge.
- R3: The clear latch returns to 0 on the first clock edge at which status is already 0, unless the clear address is written at that edge. A later single write of 1 therefore clears a newly set status.
- R4: When a change event and a clearing write fall on the same clock edge, status stays 1 and the clear latch stays 1.
- R5: While the clear latch is 1, a write of 1 to offset 0xC leaves status unchanged.
- R6: A write of 0 to offset 0xC forces the clear latch to 0. A write of 1 on the next clock edge then clears status.
- R7: A read of offset 0xC returns all zeros.
- R8: The mask register at offset 0x4 stores bit 1 of the written word and reads it back in bit 1. All other bits read 0. Reads return data in the same cycle that `bus_sel` is high and `bus_wr` is low. At all other times the read data is 0.
- R9: Offset 0x8 reads raw status AND mask in bit 1, and `irq_out` equals that bit.
- R10: Reset, sampled at a clock edge with `rst_n` low, clears status, mask and the clear latch. The synchroniser is loaded with the current `cts_in` level, so a line held steady through reset gives no status after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, sampled at the clock edge |
| cts_in | input | 1 | Asynchronous clear-to-send line |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when no read |
| irq_out | output | 1 | Masked interrupt request |

## Verification
The collision that matters is a change event arriving at the same edge as a clearing write to the latch. The bench provokes it by toggling `cts_in` one idle cycle before issuing the clear, so that the write lands on the edge where the synchronised change is detected. A behavioural reference model of the status, latch, mask and synchroniser delay is compared with `irq_out` and the read data on every cycle. The model judges the collision by status staying 1, by a repeated write of 1 having no effect, and by the write-0-then-1 sequence clearing it. A randomised phase that mixes line changes with bus traffic then hunts for further same-edge coincidences.

// File: rtl/cts_irq_pkg.sv
package cts_irq_pkg;
   // word index of each register (byte offset / 4)
   typedef enum logic [1:0] {
      SEL_RAW   = 2'd0,
      SEL_MASK  = 2'd1,
      SEL_MSTAT = 2'd2,
      SEL_CLR   = 2'd3
   } reg_sel_e;

   localparam int unsigned WORD_LSB = 2;
endpackage

// File: rtl/cts_sync_edge.sv
module cts_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_in,
   output logic edge_pulse
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cts_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= {STAGES{cts_in}};
         prev_q  <= cts_in;
      end else begin
         chain_q <= {chain_q[LAST-1:0], cts_in};
         prev_q  <= chain_q[LAST];
      end
   end

   assign edge_pulse = chain_q[LAST] ^ prev_q;
endmodule

// File: rtl/cts_clr_latch.sv
module cts_clr_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_wr,
   input  logic clr_bit,
   output logic status_q
);
   logic clr_q;
   logic clr_rise;

   assign clr_rise = clr_wr && clr_bit && !clr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= 1'b0;
         clr_q    <= 1'b0;
      end else begin
         if (set_evt)
            status_q <= 1'b1;
         else if (clr_rise)
            status_q <= 1'b0;

         if (clr_wr)
            clr_q <= clr_bit;
         else if (!status_q)
            clr_q <= 1'b0;
      end
   end

   // R1
   set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q) |-> $past(set_evt));
   // R2
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_bit && !clr_q && !set_evt) |=> !status_q);
   // R3
   latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_q && !clr_wr) |=> !clr_q);
   // R4
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> status_q);
   // R5
   stuck_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_bit && clr_q && !set_evt) |=> $stable(status_q));
endmodule

// File: rtl/cts_regbank.sv
module cts_regbank
   import cts_irq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SRC_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              status,
   output logic              clr_wr,
   output logic              clr_bit,
   output logic              mask_q,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int unsigned HI_LSB = WORD_LSB + 2;

   reg_sel_e word;
   logic     hi_ok;
   logic     hit_wr;

   assign word = reg_sel_e'(bus_addr[WORD_LSB+1:WORD_LSB]);

   generate
      if (ADDR_W > HI_LSB) begin : g_hi_dec
         assign hi_ok = (bus_addr[ADDR_W-1:HI_LSB] == '0);
      end else begin : g_no_hi
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign hit_wr  = bus_sel && bus_wr && hi_ok;
   assign clr_wr  = hit_wr && (word == SEL_CLR);
   assign clr_bit = bus_wdata[SRC_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)
         mask_q <= 1'b0;
      else if (hit_wr && word == SEL_MASK)
         mask_q <= bus_wdata[SRC_BIT];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr && hi_ok) begin
         unique case (word)
            SEL_RAW:   bus_rdata[SRC_BIT] = status;
            SEL_MASK:  bus_rdata[SRC_BIT] = mask_q;
            SEL_MSTAT: bus_rdata[SRC_BIT] = status && mask_q;
            SEL_CLR:   bus_rdata = '0;
            default:   bus_rdata = '0;
         endcase
      end
   end

   // R8
   mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wr && word == SEL_MASK) |=> (mask_q == $past(bus_wdata[SRC_BIT])));
   // R7
   clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && word == SEL_CLR) |-> (bus_rdata == '0));
endmodule

// File: rtl/cts_evt_irq.sv
module cts_evt_irq #(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SRC_BIT     = 1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cts_in,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);
   generate
      if (SRC_BIT >= DATA_W) begin : g_bad_bit
         $error("cts_evt_irq: SRC_BIT outside data width");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("cts_evt_irq: ADDR_W must cover four word registers");
      end
   endgenerate

   logic edge_pulse;
   logic status_q;
   logic mask_q;
   logic clr_wr;
   logic clr_bit;

   cts_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .cts_in     (cts_in),
      .edge_pulse (edge_pulse)
   );

   cts_clr_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_evt  (edge_pulse),
      .clr_wr   (clr_wr),
      .clr_bit  (clr_bit),
      .status_q (status_q)
   );

   cts_regbank #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .SRC_BIT (SRC_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .status    (status_q),
      .clr_wr    (clr_wr),
      .clr_bit   (clr_bit),
      .mask_q    (mask_q),
      .bus_rdata (bus_rdata)
   );

   assign irq_out = status_q && mask_q;

   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !irq_out);
endmodule

// File: tb/cts_evt_irq_test.sv
`timescale 1ns/1ps
module cts_evt_irq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cts_in = 1'b1;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R10";

   // reference model state
   bit h0, h1, hp, m_st, m_clr, m_mask;

   always #2.5 clk = ~clk;

   cts_evt_irq uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cts_in    (cts_in),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   always @(posedge clk) begin
      bit ev, clrw, b, rise, n_st;
      if (!rst_n) begin
         h0 = cts_in; h1 = cts_in; hp = cts_in;
         m_st = 0; m_clr = 0; m_mask = 0;
      end else begin
         ev   = (h1 != hp);
         clrw = bus_sel && bus_wr && bus_addr == 4'hC;
         b    = bus_wdata[1];
         rise = clrw && b && !m_clr;
         n_st = ev ? 1'b1 : (rise ? 1'b0 : m_st);
         if (clrw) m_clr = b;
         else if (!m_st) m_clr = 0;
         if (bus_sel && bus_wr && bus_addr == 4'h4) m_mask = b;
         m_st = n_st;
         hp = h1; h1 = h0; h0 = cts_in;
      end
   end

   task automatic check_now();
      logic [31:0] exp_rd;
      logic        exp_irq;
      exp_irq = m_st & m_mask;
      exp_rd  = '0;
      if (bus_sel && !bus_wr) begin
         case (bus_addr)
            4'h0: exp_rd[1] = m_st;
            4'h4: exp_rd[1] = m_mask;
            4'h8: exp_rd[1] = m_st & m_mask;
            default: exp_rd = '0;
         endcase
      end
      checks++;
      if (irq_out !== exp_irq) begin
         fails++;
         $display("FAIL %s irq_out actual %b expected %b at %0t", cur_req, irq_out, exp_irq, $time);
      end
      checks++;
      if (bus_rdata !== exp_rd) begin
         fails++;
         $display("FAIL %s bus_rdata actual %h expected %h at %0t", cur_req, bus_rdata, exp_rd, $time);
      end
   endtask

   task automatic step(input bit s, input bit w, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      check_now();
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 4'h0, '0);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      step(1, 1, a, d);
   endtask

   task automatic rd(input logic [3:0] a);
      step(1, 0, a, '0);
   endtask

   task automatic flip();
      @(negedge clk);
      check_now();
      cts_in = ~cts_in;
      bus_sel = 0; bus_wr = 0;
   endtask

   initial begin
      #(200000 * 5);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      // R10: reset with line high, no spurious event afterwards
      cur_req = "R10";
      idle(4);
      @(negedge clk); check_now(); rst_n = 1'b1;
      idle(5);
      rd(4'h0); rd(4'h4); idle(1);
      // R8: mask write/read
      cur_req = "R8";
      wr(4'h4, 32'hFFFF_FFFF); rd(4'h4); step(0, 1, 4'h4, '0); rd(4'h4);
      // R1: falling change, latency
      cur_req = "R1";
      flip(); rd(4'h0); rd(4'h0); rd(4'h0); rd(4'h0);
      // R9: masked status and irq
      cur_req = "R9";
      rd(4'h8);
      // R2: single clear
      cur_req = "R2";
      wr(4'hC, 32'h2); rd(4'h0); rd(4'h0);
      // R3: rising change, latch released, single write clears again
      cur_req = "R3";
      flip(); idle(4); rd(4'h0); wr(4'hC, 32'h2); rd(4'h0); idle(1);
      // R7
      cur_req = "R7";
      rd(4'hC);
      // R4: change event and clear on the same edge
      cur_req = "R4";
      flip(); idle(4); rd(4'h0);
      flip(); idle(1); wr(4'hC, 32'h2); rd(4'h0); rd(4'h0);
      // R5: latch held at 1, write of 1 has no effect
      cur_req = "R5";
      wr(4'hC, 32'h2); rd(4'h0); idle(2); rd(4'h0);
      // R6: write 0 then 1 clears
      cur_req = "R6";
      wr(4'hC, 32'h0); wr(4'hC, 32'h2); rd(4'h0); rd(4'h8);
      // R9: masked off
      cur_req = "R9";
      wr(4'h4, 32'h0); flip(); idle(4); rd(4'h0); rd(4'h8);
      wr(4'h4, 32'h2); rd(4'h8);
      // mixed random traffic
      cur_req = "R4";
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r < 2) flip();
         else if (r < 5) wr(4'hC, {30'd0, 1'($urandom_range(0, 1)), 1'b0});
         else if (r < 6) wr(4'h4, $urandom);
         else if (r < 9) rd(4'($urandom_range(0, 3) * 4));
         else idle(1);
      end
      idle(2);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule